// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-select code. Two ways exist to change them. A set of parallel pins, qualified by an active-low parallel strobe, writes the feedback and post-divide values. A three-wire serial port (data, shift clock, load line) fills a 14-bit shift register, and the load line moves that word into the registers or lets it flow straight through.

The strobes and the serial clock come from slow, unrelated sources. All of them are brought into one system clock through two-stage synchronizers, and every edge of a strobe is detected in that clock domain. Each strobe level must therefore be held for at least two system clocks. Whichever path acted last owns the registered values, so a serial event overwrites a parallel setting and the other way round.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the feedback value is all ones (0x1FF), the post-divide code is all ones (2'b11), the test code is 3'b000 and the serial output is 0.
- R2: While the parallel strobe is low, the feedback and post-divide outputs follow the parallel pins and the test code is held at 3'b000.
- R3: On the rising edge of the parallel strobe the pin values are captured, and later changes on the pins have no effect on the outputs.
- R4: With the parallel strobe high and the serial load line low, each shift-clock rising edge shifts the data bit into bit 0 of the shift register. The most significant bit (bit 13) drives the serial output, so the first bit of a 14-bit frame appears there after 14 shifts.
- R5: A rising edge of the serial load line copies the shift register to the outputs, with bits 13:11 giving the test code, bits 10:9 the post-divide code and bits 8:0 the feedback value. The frame is therefore sent test code MSB first and feedback LSB last.
- R6: After the serial load line falls, the outputs stay latched, and further shifting does not change them.
- R7: While the serial load line is held high, each shift-clock rising edge shifts the register and also updates the outputs with the shifted word.
- R8: A serial load replaces values set through the parallel pins. A low parallel strobe replaces values set serially.
- R9: When no shift-clock edge occurs, neither parallel strobes nor parallel pin activity alter the shift register.
- R10: An output change caused by a strobe or shift-clock edge appears on the third system clock edge after the input edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Active-low parallel strobe |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load line |
| m_val | output | 9 | Registered feedback divide value |
| n_val | output | 2 | Registered post-divide code |
| t_val | output | 3 | Registered test-select code |
| ser_out | output | 1 | Shift register MSB, used as test data |

## Verification
On every cycle, the assertions check four things: the test code is forced to zero while the parallel strobe is low; the outputs hold when no event is pending; a serial load transfers exactly the previous shift-register word; and the shift register stays still when no shift edge occurs. The bench scenarios cover what the assertions cannot show. These are the shift order and field layout of a whole frame, flow-through updates, one path overriding the other, the register staying undisturbed across a parallel episode, and the three-edge latency.

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int M_W  = 9,
  parameter int N_W  = 2,
  parameter int T_W  = 3,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           ser_out
);
  localparam int SR_W = T_W + N_W + M_W;

  logic [SYNC:0]   pl_sy, sl_sy, sc_sy;
  logic [SYNC-1:0] sd_sy;
  logic [SR_W-1:0] sr, sr_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pl_sy <= '1;
      sl_sy <= '0;
      sc_sy <= '0;
      sd_sy <= '0;
    end else begin
      pl_sy <= {pl_sy[SYNC-1:0], par_load_n};
      sl_sy <= {sl_sy[SYNC-1:0], ser_load};
      sc_sy <= {sc_sy[SYNC-1:0], ser_clk};
      sd_sy <= {sd_sy[SYNC-2:0], ser_data};
    end

  wire pl_q      = pl_sy[SYNC-1];
  wire pl_d      = pl_sy[SYNC];
  wire sl_q      = sl_sy[SYNC-1];
  wire sl_rise   = sl_q & ~sl_sy[SYNC];
  wire sclk_rise = sc_sy[SYNC-1] & ~sc_sy[SYNC];
  wire shift_en  = sclk_rise & pl_q;

  assign sr_next = {sr[SR_W-2:0], sd_sy[SYNC-1]};
  assign ser_out = sr[SR_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr    <= '0;
      m_val <= '1;
      n_val <= '1;
      t_val <= '0;
    end else begin
      if (shift_en) sr <= sr_next;
      if (!pl_q || !pl_d) begin
        m_val <= par_m;
        n_val <= par_n;
        t_val <= '0;
      end else if (sl_rise) begin
        {t_val, n_val, m_val} <= sr;
      end else if (sl_q && sclk_rise) begin
        {t_val, n_val, m_val} <= sr_next;
      end
    end

  // R2: test code forced to zero while the parallel strobe is low
  a_r2_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_q |=> (t_val == '0));

  // R6: no pending event leaves the outputs unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_q && pl_d && !sl_rise && !(sl_q && sclk_rise)) |=> $stable({t_val, n_val, m_val}));

  // R5: serial load moves the previous shift word to the outputs
  a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_q && pl_d && sl_rise) |=> ({t_val, n_val, m_val} == $past(sr)));

  // R9: shift register only moves on a shift edge
  a_r9_sr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));
endmodule

// File: tb/synth_cfg_loader_tb_top.sv
module synth_cfg_loader_tb_top;
  logic clk = 0, rst_n = 0;
  logic par_load_n = 1, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] par_m = 0;
  logic [1:0] par_n = 0;
  logic [8:0] m_val;
  logic [1:0] n_val;
  logic [2:0] t_val;
  logic ser_out;
  int checks = 0, errors = 0;
  logic [13:0] exp_cfg, exp_sr;

  always #5 clk = ~clk;

  synth_cfg_loader dut_i (.clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .ser_out(ser_out));

  function automatic logic [13:0] shift_in(input logic [13:0] s, input logic b);
    return {s[12:0], b};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(req, {18'd0, t_val, n_val, m_val}, {18'd0, exp_cfg});
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    tick(3);
    ser_clk = 1;
    tick(4);
    exp_sr = shift_in(exp_sr, b);
    if (ser_load) exp_cfg = exp_sr;
    ser_clk = 0;
    tick(3);
  endtask

  task automatic shift_frame(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic ser_commit;
    ser_load = 1;
    tick(5);
    exp_cfg = exp_sr;
    chk_cfg("R5 serial transfer");
    ser_load = 0;
    tick(5);
    chk_cfg("R6 latched after load fall");
  endtask

  task automatic par_cycle(input logic [8:0] m, input logic [1:0] n);
    par_m = m; par_n = n; par_load_n = 0;
    tick(5);
    exp_cfg = {3'b000, n, m};
    chk_cfg("R2 parallel follow");
    par_load_n = 1;
    tick(5);
    par_m = 9'($urandom); par_n = 2'($urandom);
    tick(5);
    chk_cfg("R3 parallel held");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [13:0] w;
    void'($urandom(32'd4242));
    exp_sr = '0;
    tick(3);
    rst_n = 1;
    tick(5);
    exp_cfg = {3'b000, 2'b11, 9'h1FF};
    chk_cfg("R1 reset");
    chk("R1 ser_out reset", {31'd0, ser_out}, 32'd0);

    par_cycle(9'h0A5, 2'd2);
    par_m = 9'h155; par_n = 2'd1; par_load_n = 0;
    tick(5);
    exp_cfg = {3'b000, 2'd1, 9'h155};
    chk_cfg("R2 follow second value");
    par_load_n = 1;
    tick(5);
    par_m = 9'h033; par_n = 2'd0;
    tick(5);
    chk_cfg("R3 pins ignored");

    w = 14'b101_10_110010000;
    shift_frame(w);
    chk_cfg("R6 shifting with load low leaves outputs");
    chk("R4 ser_out is first bit", {31'd0, ser_out}, {31'd0, w[13]});
    ser_load = 1;
    tick(2);
    chk_cfg("R10 no change after two edges");
    tick(1);
    exp_cfg = exp_sr;
    chk("R10 change on third edge", {18'd0, t_val, n_val, m_val}, {18'd0, w});
    chk("R5 test field", {29'd0, t_val}, {29'd0, w[13:11]});
    chk("R5 post field", {30'd0, n_val}, {30'd0, w[10:9]});
    chk("R5 feedback field", {23'd0, m_val}, {23'd0, w[8:0]});
    ser_load = 0;
    tick(5);

    shift_frame(14'h2C3A);
    chk_cfg("R6 second frame not applied");
    ser_load = 1;
    tick(5);
    exp_cfg = exp_sr;
    chk_cfg("R8 serial overrides parallel");
    shift_bit(1'b1);
    chk_cfg("R7 flow-through bit 1");
    shift_bit(1'b0);
    chk_cfg("R7 flow-through bit 0");
    ser_load = 0;
    tick(5);

    w = 14'h1B6E;
    shift_frame(w);
    par_cycle(9'h0F0, 2'd3);
    chk_cfg("R8 parallel overrides serial");
    chk("R9 ser_out kept", {31'd0, ser_out}, {31'd0, exp_sr[13]});
    ser_commit();
    chk("R9 shift register intact", {18'd0, t_val, n_val, m_val}, {18'd0, w});

    for (int it = 0; it < 20; it++) begin
      case ($urandom % 3)
        0: par_cycle(9'($urandom), 2'($urandom));
        1: begin shift_frame(14'($urandom)); ser_commit(); end
        default: begin
          ser_load = 1;
          tick(5);
          exp_cfg = exp_sr;
          shift_bit(1'($urandom));
          chk_cfg("R7 random flow-through");
          ser_load = 0;
          tick(5);
        end
      endcase
      chk("R4 random ser_out", {31'd0, ser_out}, {31'd0, exp_sr[13]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule